// File: doc/BRIEF.md
# Port Status LED and Timing-Marker Pulser

This block holds the per-port status indication and the 8 kHz timing-marker handling of a four-port cell transceiver. It runs on the reference oscillator clock. Each port has two active-low LED outputs. The transmit LED lights when a cell start is accepted for transmission on that port. The receive LED lights when a cell start arrives on that port and the cell is neither idle (null) nor errored. Each LED stays lit for a fixed 223 oscillator cycles. A new qualifying event that arrives while the LED is lit restarts the count.

A single active-low receive reference output pulses when a timing-marker command is detected on one chosen port. The pulse width is programmable, and the width setting of 0 gives the shortest pulse of one cycle. The block also synchronises an external, asynchronous transmit reference input. Each falling edge of that input becomes a one-cycle request to insert a timing-marker command on the chosen port. A configuration check is raised when the chosen port runs at a 2x or 4x clock multiplier while the width is left at its shortest setting. Marker detection and marker insertion in the line code belong to other blocks, and here they are plain strobes.

Top module: `port_status_pulser`

## Requirements
- R1: After reset, every LED output and `rxRefN` are high, `markerInsertReq` is all zero and `cfgError` is low.
- R2: A strobe on `rxCellSoc[i]` with `rxCellNull[i]` and `rxCellErr[i]` both low drives `rxLedN[i]` low from the next cycle for exactly 223 cycles.
- R3: A receive cell start that has `rxCellNull[i]` or `rxCellErr[i]` high leaves `rxLedN[i]` unchanged.
- R4: A strobe on `txCellSoc[i]` drives `txLedN[i]` low from the next cycle for exactly 223 cycles.
- R5: A qualifying event while an LED is lit restarts its 223-cycle count, so the LED stays low until 223 cycles after the last event.
- R6: A strobe on `rxMarkerSeen[refPortSel]` drives `rxRefN` low from the next cycle for `refPulseWidth + 1` cycles. Strobes on other ports have no effect.
- R7: Each falling edge of `txRefN` raises bit `refPortSel` of `markerInsertReq` for exactly one cycle, two clock edges after the edge is first sampled. All other bits stay low. A rising edge or a held level raises nothing.
- R8: One cycle after `refPulseWidth` is 0 while the 2-bit multiplier code of port `refPortSel` in `portMult` (bits [2*p+1:2*p]; 00 = 1x, 01 = 2x, 10 = 4x) is not 00, `cfgError` is high. Otherwise it is low.
- R9: The LED outputs of each port and each direction respond only to that port's own events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txCellSoc | input | 4 | Per-port strobe: transmit cell start accepted |
| rxCellSoc | input | 4 | Per-port strobe: receive cell start |
| rxCellNull | input | 4 | Per-port qualifier: received cell is idle |
| rxCellErr | input | 4 | Per-port qualifier: received cell is errored |
| rxMarkerSeen | input | 4 | Per-port strobe: timing-marker command received |
| refPortSel | input | 2 | Port chosen for marker reference and insertion |
| refPulseWidth | input | 4 | Receive reference width minus one, in cycles |
| portMult | input | 8 | Per-port clock multiplier code, 2 bits per port |
| txRefN | input | 1 | Asynchronous transmit reference, falling edge active |
| txLedN | output | 4 | Per-port transmit LED, active low |
| rxLedN | output | 4 | Per-port receive LED, active low |
| rxRefN | output | 1 | Receive reference pulse, active low |
| markerInsertReq | output | 4 | One-cycle request to insert a marker, per port |
| cfgError | output | 1 | Shortest width programmed while the chosen port is above 1x |

## Verification
The LED outputs and `rxRefN` change one clock edge after their strobe, because a single counter register lies between them. `cfgError` also follows its inputs by one edge. `markerInsertReq` appears two edges after `txRefN` falls, since the input passes through a two-flop synchroniser before the edge detector. The bench drives inputs on the falling clock edge and samples on the falling edge that follows the expected rising edge. It measures each pulse length by counting the falling edges that see the output low.

// File: rtl/psp_pkg.sv
package psp_pkg;
  localparam int PORTS = 4;

  typedef struct packed {
    logic [PORTS-1:0] txStart;
    logic [PORTS-1:0] rxStart;
    logic             refStart;
  } pspStrobes_t;
endpackage

// File: rtl/psp_ctrl.sv
module psp_ctrl
  import psp_pkg::*;
#(
  parameter int SEL_BITS   = 2,
  parameter int WIDTH_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PORTS-1:0]      txCellSoc,
  input  logic [PORTS-1:0]      rxCellSoc,
  input  logic [PORTS-1:0]      rxCellNull,
  input  logic [PORTS-1:0]      rxCellErr,
  input  logic [PORTS-1:0]      rxMarkerSeen,
  input  logic [SEL_BITS-1:0]   refPortSel,
  input  logic [WIDTH_BITS-1:0] refPulseWidth,
  input  logic [2*PORTS-1:0]    portMult,
  input  logic                  txRefN,
  output pspStrobes_t           strobes,
  output logic [PORTS-1:0]      markerInsertReq,
  output logic                  cfgError
);
  // Two-flop synchroniser, then one stage for edge detection
  logic refSync1, refSync2, refSync3;
  logic refFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSync1 <= 1'b1;
      refSync2 <= 1'b1;
      refSync3 <= 1'b1;
    end else begin
      refSync1 <= txRefN;
      refSync2 <= refSync1;
      refSync3 <= refSync2;
    end
  end

  assign refFall = refSync3 & ~refSync2;

  always_comb begin
    markerInsertReq = '0;
    if (refFall) markerInsertReq[refPortSel] = 1'b1;
  end

  always_comb begin
    strobes.txStart  = txCellSoc;
    strobes.rxStart  = rxCellSoc & ~rxCellNull & ~rxCellErr;
    strobes.refStart = rxMarkerSeen[refPortSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgError <= 1'b0;
    else       cfgError <= (refPulseWidth == '0) && (portMult[refPortSel*2 +: 2] != 2'b00);
  end

  // R7: a request lasts one cycle only
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (|markerInsertReq) |=> !(|markerInsertReq));
  // R7: at most one port requested
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(markerInsertReq));
endmodule

// File: rtl/psp_datapath.sv
module psp_datapath
  import psp_pkg::*;
#(
  parameter int LED_CYCLES = 223,
  parameter int WIDTH_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pspStrobes_t           strobes,
  input  logic [WIDTH_BITS-1:0] refPulseWidth,
  output logic [PORTS-1:0]      txLedN,
  output logic [PORTS-1:0]      rxLedN,
  output logic                  rxRefN
);
  localparam int CNT_BITS = $clog2(LED_CYCLES + 1);
  localparam int REF_BITS = WIDTH_BITS + 1;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [CNT_BITS-1:0] txCnt, rxCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   txCnt <= '0;
      else if (strobes.txStart[p]) txCnt <= CNT_BITS'(LED_CYCLES);
      else if (txCnt != '0)        txCnt <= txCnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   rxCnt <= '0;
      else if (strobes.rxStart[p]) rxCnt <= CNT_BITS'(LED_CYCLES);
      else if (rxCnt != '0)        rxCnt <= rxCnt - 1'b1;
    end

    assign txLedN[p] = (txCnt == '0);
    assign rxLedN[p] = (rxCnt == '0);

    // R5: a restart reloads the full count
    a_r5_reload: assert property (@(posedge clk) disable iff (!rstN)
      strobes.rxStart[p] |=> (rxCnt == CNT_BITS'(LED_CYCLES)));
  end

  logic [REF_BITS-1:0] refCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 refCnt <= '0;
    else if (strobes.refStart) refCnt <= {1'b0, refPulseWidth} + 1'b1;
    else if (refCnt != '0)     refCnt <= refCnt - 1'b1;
  end

  assign rxRefN = (refCnt == '0);
endmodule

// File: rtl/port_status_pulser.sv
module port_status_pulser
  import psp_pkg::*;
#(
  parameter int LED_CYCLES = 223,
  parameter int WIDTH_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PORTS-1:0]      txCellSoc,
  input  logic [PORTS-1:0]      rxCellSoc,
  input  logic [PORTS-1:0]      rxCellNull,
  input  logic [PORTS-1:0]      rxCellErr,
  input  logic [PORTS-1:0]      rxMarkerSeen,
  input  logic [$clog2(PORTS)-1:0] refPortSel,
  input  logic [WIDTH_BITS-1:0] refPulseWidth,
  input  logic [2*PORTS-1:0]    portMult,
  input  logic                  txRefN,
  output logic [PORTS-1:0]      txLedN,
  output logic [PORTS-1:0]      rxLedN,
  output logic                  rxRefN,
  output logic [PORTS-1:0]      markerInsertReq,
  output logic                  cfgError
);
  localparam int SEL_BITS = $clog2(PORTS);

  pspStrobes_t strobes;

  psp_ctrl #(.SEL_BITS(SEL_BITS), .WIDTH_BITS(WIDTH_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .txCellSoc(txCellSoc), .rxCellSoc(rxCellSoc),
    .rxCellNull(rxCellNull), .rxCellErr(rxCellErr),
    .rxMarkerSeen(rxMarkerSeen), .refPortSel(refPortSel),
    .refPulseWidth(refPulseWidth), .portMult(portMult),
    .txRefN(txRefN), .strobes(strobes),
    .markerInsertReq(markerInsertReq), .cfgError(cfgError)
  );

  psp_datapath #(.LED_CYCLES(LED_CYCLES), .WIDTH_BITS(WIDTH_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .refPulseWidth(refPulseWidth),
    .txLedN(txLedN), .rxLedN(rxLedN), .rxRefN(rxRefN)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    // R2: a good received cell lights the LED on the next cycle
    a_r2_rx_on: assert property (@(posedge clk) disable iff (!rstN)
      (rxCellSoc[p] && !rxCellNull[p] && !rxCellErr[p]) |=> !rxLedN[p]);
    // R3: a null or errored cell does not light an idle LED
    a_r3_rx_ignore: assert property (@(posedge clk) disable iff (!rstN)
      (rxLedN[p] && rxCellSoc[p] && (rxCellNull[p] || rxCellErr[p])) |=> rxLedN[p]);
    // R4: a transmit cell start lights the LED on the next cycle
    a_r4_tx_on: assert property (@(posedge clk) disable iff (!rstN)
      txCellSoc[p] |=> !txLedN[p]);
  end

  // R6: a marker on the chosen port starts the reference pulse
  a_r6_ref_on: assert property (@(posedge clk) disable iff (!rstN)
    rxMarkerSeen[refPortSel] |=> !rxRefN);
  // R8: shortest width with a fast chosen port is flagged
  a_r8_cfg: assert property (@(posedge clk) disable iff (!rstN)
    ((refPulseWidth == '0) && (portMult[refPortSel*2 +: 2] != 2'b00)) |=> cfgError);
endmodule

// File: tb/port_status_pulser_tb.sv
module port_status_pulser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LED_LEN = 223;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] txCellSoc = '0, rxCellSoc = '0, rxCellNull = '0, rxCellErr = '0, rxMarkerSeen = '0;
  logic [1:0] refPortSel = '0;
  logic [3:0] refPulseWidth = '0;
  logic [7:0] portMult = '0;
  logic txRefN = 1'b1;
  logic [3:0] txLedN, rxLedN, markerInsertReq;
  logic rxRefN, cfgError;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_status_pulser dut_i (
    .clk(clk), .rstN(rstN), .txCellSoc(txCellSoc), .rxCellSoc(rxCellSoc),
    .rxCellNull(rxCellNull), .rxCellErr(rxCellErr), .rxMarkerSeen(rxMarkerSeen),
    .refPortSel(refPortSel), .refPulseWidth(refPulseWidth), .portMult(portMult),
    .txRefN(txRefN), .txLedN(txLedN), .rxLedN(rxLedN), .rxRefN(rxRefN),
    .markerInsertReq(markerInsertReq), .cfgError(cfgError)
  );

  // Row: {port[1:0], null, err, expectLit}
  localparam logic [4:0] RX_VEC [6] = '{
    5'b00_0_0_1, 5'b01_1_0_0, 5'b10_0_1_0, 5'b11_1_1_0, 5'b11_0_0_1, 5'b10_0_0_1
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int which, input int idx);
    case (which)
      0:       return rxLedN[idx];
      1:       return txLedN[idx];
      default: return rxRefN;
    endcase
  endfunction

  task automatic lowLen(input int which, input int idx, output int len);
    len = 0;
    while (sig(which, idx) == 1'b0 && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 txLedN", txLedN, 4'hF);
    chk("R1 rxLedN", rxLedN, 4'hF);
    chk("R1 rxRefN", rxRefN, 1);
    chk("R1 req", markerInsertReq, 0);
    chk("R1 cfgError", cfgError, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3 vector walk
    for (int v = 0; v < 6; v++) begin
      int p = int'(RX_VEC[v][4:3]);
      rxCellSoc[p] = 1'b1;
      rxCellNull[p] = RX_VEC[v][2];
      rxCellErr[p] = RX_VEC[v][1];
      @(negedge clk);
      rxCellSoc = '0; rxCellNull = '0; rxCellErr = '0;
      if (RX_VEC[v][0]) begin
        lowLen(0, p, len);
        chk("R2 rx LED length", len, LED_LEN);
      end else begin
        repeat (5) begin
          chk("R3 rx LED ignores null/errored", rxLedN[p], 1);
          @(negedge clk);
        end
      end
      repeat (2) @(negedge clk);
    end

    // R4 and R9: transmit LED on port 2, others stay dark
    txCellSoc[2] = 1'b1;
    @(negedge clk);
    txCellSoc = '0;
    chk("R9 other tx LEDs", txLedN & 4'b1011, 4'b1011);
    chk("R9 rx LEDs untouched", rxLedN, 4'hF);
    lowLen(1, 2, len);
    chk("R4 tx LED length", len, LED_LEN);

    // R5: restart after 100 lit cycles
    rxCellSoc[1] = 1'b1;
    @(negedge clk);
    rxCellSoc = '0;
    repeat (99) @(negedge clk);
    rxCellSoc[1] = 1'b1;
    @(negedge clk);
    rxCellSoc = '0;
    lowLen(0, 1, len);
    chk("R5 restart remaining length", len, LED_LEN);

    // R6: reference pulse on chosen port, width 3 -> 4 cycles
    refPortSel = 2'd2;
    refPulseWidth = 4'd3;
    rxMarkerSeen[1] = 1'b1;
    @(negedge clk);
    rxMarkerSeen = '0;
    chk("R6 other port ignored", rxRefN, 1);
    rxMarkerSeen[2] = 1'b1;
    @(negedge clk);
    rxMarkerSeen = '0;
    lowLen(2, 0, len);
    chk("R6 ref pulse width", len, 4);
    refPulseWidth = 4'd0;
    rxMarkerSeen[2] = 1'b1;
    @(negedge clk);
    rxMarkerSeen = '0;
    lowLen(2, 0, len);
    chk("R6 ref default width", len, 1);

    // R7: falling edge of txRefN, chosen port 3
    refPortSel = 2'd3;
    txRefN = 1'b0;
    @(negedge clk);
    chk("R7 req not yet", markerInsertReq, 0);
    @(negedge clk);
    chk("R7 req on chosen port", markerInsertReq, 4'b1000);
    @(negedge clk);
    chk("R7 req one cycle", markerInsertReq, 0);
    repeat (4) @(negedge clk);
    chk("R7 held low no repeat", markerInsertReq, 0);
    txRefN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R7 rising edge ignored", markerInsertReq, 0);
    end

    // R8: configuration check
    refPortSel = 2'd1;
    portMult = 8'b00_00_01_00;
    refPulseWidth = 4'd0;
    @(negedge clk);
    chk("R8 2x with width 0", cfgError, 1);
    refPulseWidth = 4'd1;
    @(negedge clk);
    chk("R8 2x with width 1", cfgError, 0);
    refPulseWidth = 4'd0;
    refPortSel = 2'd0;
    @(negedge clk);
    chk("R8 1x port with width 0", cfgError, 0);
    portMult = 8'b00_00_00_10;
    @(negedge clk);
    chk("R8 4x with width 0", cfgError, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule